// File: doc/BRIEF.md
# Indirect Address/Data Access Window

This block gives a host an I/O window of two registers to reach a larger backing space. The host first writes a target address into the pointer register at offset 0. It then reads or writes the data register at offset 4. Each data access goes to the backing location named by the stored pointer. Pointer values are split into three regions. Values below 20000h reach an internal register space. Values from 80000h up to FFFFFh reach a flash window. The range between them is a hole, and nothing is sent there.

The host bus uses a strobe-and-ready handshake. The host raises a read or write strobe with an offset, active-low byte enables and write data, and holds them until the block returns ready for one cycle. Each data access is checked before it leaves the block. The byte enables must match the low two bits of the pointer. Only the flash window accepts byte and word accesses, and the register space accepts full dwords only. An access that fails these checks is not sent out and sets a sticky error flag. A data read always returns a full 32-bit dword, and the host keeps only the lanes it enabled. When a target is slow, the host waits in the handshake until that target answers.

Top module: `iwin_port`

## Requirements
- R1: After reset the pointer reads back as zero, `err_o` is low, `h_ready` is low and no back-side strobe is active.
- R2: A write to offset 0 with `h_be_n` = 0000 stores `h_wdata[19:0]` as the pointer. A read of offset 0 returns the pointer zero-extended to 32 bits. Both kinds of offset-0 access finish with `h_ready` high in the cycle after the strobe is first sampled.
- R3: A write to offset 0 with any `h_be_n` other than 0000 leaves the pointer unchanged and sets `err_o`.
- R4: With the pointer P in 80000h..FFFFFh, these lane patterns are legal for a data access. Byte: P[1:0] = 00, 01, 10, 11 with `h_be_n` = 1110, 1101, 1011, 0111. Word: P[1:0] = 00, 10 with `h_be_n` = 1100, 0011. Dword: P[1:0] = 00 with `h_be_n` = 0000. A legal access raises `fl_rd` or `fl_wr` with `bk_addr` equal to P with bits [1:0] cleared, `bk_be_n` equal to `h_be_n`, and `bk_wdata` equal to `h_wdata`.
- R5: With P in the flash window, any other pattern of `h_be_n` and P[1:0] (including 1111) is not sent out. It completes in one cycle, a read returns zero, and `err_o` is set.
- R6: With P below 20000h, only `h_be_n` = 0000 with P[1:0] = 00 is sent out, on `reg_rd` or `reg_wr`, with `bk_addr` = P. Every other pattern there is blocked, reads zero and sets `err_o`.
- R7: With P in 20000h..7FFFFh, no access is sent out and every read returns zero. A dword access with P[1:0] = 00 leaves `err_o` unchanged. Every other pattern there sets `err_o`.
- R8: A sent-out read returns the target's full 32-bit read data whatever `h_be_n` is. A write returns zero.
- R9: A sent-out access holds its strobe and its back-side fields until the target's ready is sampled high. `h_ready` rises in the cycle after that sample, so with w wait cycles at the target it appears 2+w cycles after the host strobe is first sampled.
- R10: Once set, `err_o` stays high through any later accesses until reset.
- R11: Accesses to offsets other than 0 and 4 complete in one cycle, read zero, send nothing out, leave the pointer unchanged and do not set `err_o`.
- R12: `h_ready` is high for exactly one cycle per access, and `h_rdata` is zero whenever `h_ready` is low.
- R13: At most one of `reg_rd`, `reg_wr`, `fl_rd`, `fl_wr` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_ofs | input | 3 | Host I/O offset inside the window (0 pointer, 4 data) |
| h_be_n | input | 4 | Host byte enables, active low |
| h_rd | input | 1 | Host read strobe, held until ready |
| h_wr | input | 1 | Host write strobe, held until ready |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid while ready |
| h_ready | output | 1 | One-cycle completion of a host access |
| err_o | output | 1 | Sticky access-error flag |
| bk_addr | output | 20 | Back-side dword address |
| bk_be_n | output | 4 | Back-side byte enables, active low |
| bk_wdata | output | 32 | Back-side write data |
| reg_rd | output | 1 | Register-space read strobe |
| reg_wr | output | 1 | Register-space write strobe |
| reg_rdata | input | 32 | Register-space read data |
| reg_ready | input | 1 | Register-space completion |
| fl_rd | output | 1 | Flash-window read strobe |
| fl_wr | output | 1 | Flash-window write strobe |
| fl_rdata | input | 32 | Flash-window read data |
| fl_ready | input | 1 | Flash-window completion |

## Verification
The assertions rely on three things from the block's inputs. The host raises only one of read or write at a time. The host keeps its strobe and fields steady until it sees ready and drops them right after. Each target raises its ready only while its own strobe is high. The bench drives the host through one task that holds the strobe until the ready is seen and then releases it. The target models compute their ready from a wait counter that runs only while their strobe is high, so the stimulus stays within these limits while the sweep covers every byte-enable pattern at every low-address offset in each region and at the region edges.

// File: rtl/iwin_pkg.sv
// Shared types of the indirect access window.
// Assumes nothing beyond being compiled before the modules that import it.
package iwin_pkg;

    // Region selected by the stored pointer.
    typedef enum logic [1:0] {
        RGN_REGS  = 2'd0,
        RGN_HOLE  = 2'd1,
        RGN_FLASH = 2'd2
    } rgn_e;

    // Access sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } st_e;

    // Routing decision for one data-register access.
    typedef struct packed {
        logic fwd;    // send the access to a back-side target
        logic flash;  // target is the flash window (else register space)
        logic err;    // access violates lane or region rules
    } route_t;

endpackage

// File: rtl/iwin_decode.sv
// Classifies the stored pointer into a region and checks the host byte
// enables against the pointer's low bits; purely combinational.
// Assumes byte enables are active low and LANES is a power of two.
module iwin_decode
    import iwin_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          LANES      = 4,
    parameter int unsigned REG_LIMIT  = 32'h0002_0000,
    parameter int unsigned FLASH_BASE = 32'h0008_0000
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [LANES-1:0]  be_n,
    output route_t            route
);

    localparam int OFS_W = $clog2(LANES);
    localparam int NSZ   = OFS_W + 1;

    logic [OFS_W-1:0] lane;
    logic [NSZ-1:0]   fit;
    logic             lane_ok;
    logic             dword_ok;
    rgn_e             rgn;

    assign lane = ptr[OFS_W-1:0];

    // One aligned-pattern match per access size: 1, 2, 4 ... LANES bytes.
    for (genvar gi = 0; gi < NSZ; gi++) begin : g_size
        localparam int               SZ   = 1 << gi;
        localparam logic [LANES-1:0] MASK = LANES'((1 << SZ) - 1);
        logic [LANES-1:0] want_n;
        assign want_n  = ~(MASK << lane);
        assign fit[gi] = ((lane & OFS_W'(SZ - 1)) == '0) && (be_n == want_n);
    end

    assign lane_ok  = |fit;
    assign dword_ok = fit[NSZ-1];

    // Region split of the pointer space.
    always_comb begin
        if (32'(ptr) < REG_LIMIT)        rgn = RGN_REGS;
        else if (32'(ptr) >= FLASH_BASE) rgn = RGN_FLASH;
        else                             rgn = RGN_HOLE;
    end

    // Routing rule: flash takes any legal size, others need a full dword.
    always_comb begin
        route.flash = (rgn == RGN_FLASH);
        route.fwd   = (route.flash && lane_ok) || ((rgn == RGN_REGS) && dword_ok);
        route.err   = route.flash ? !lane_ok : !dword_ok;
    end

endmodule

// File: rtl/iwin_seq.sv
// Access sequencer: takes a host request, either answers it locally or
// issues a registered back-side access and waits for the target's ready,
// then returns a one-cycle host ready with the captured read data.
// Assumes the host holds its strobe until ready and drops it right after.
module iwin_seq
    import iwin_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DW     = 32,
    parameter int LANES  = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              fwd,
    input  logic              flash,
    input  logic              is_wr,
    input  logic [DW-1:0]     local_rdata,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [LANES-1:0]  be_n,
    input  logic [DW-1:0]     wdata,
    output logic              accept,
    output logic              h_ready,
    output logic [DW-1:0]     h_rdata,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [LANES-1:0]  bk_be_n,
    output logic [DW-1:0]     bk_wdata,
    output logic              reg_rd,
    output logic              reg_wr,
    input  logic [DW-1:0]     reg_rdata,
    input  logic              reg_ready,
    output logic              fl_rd,
    output logic              fl_wr,
    input  logic [DW-1:0]     fl_rdata,
    input  logic              fl_ready
);

    st_e          st;
    logic         tgt_flash_q;
    logic         wr_q;
    logic [DW-1:0] rdata_q;
    logic         busy;
    logic         hit;

    assign busy   = (st == ST_BUSY);
    assign accept = (st == ST_IDLE) && req;
    assign hit    = tgt_flash_q ? fl_ready : reg_ready;

    // State, back-side fields and response data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            tgt_flash_q <= 1'b0;
            wr_q        <= 1'b0;
            rdata_q     <= '0;
            bk_addr     <= '0;
            bk_be_n     <= '1;
            bk_wdata    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req) begin
                        if (fwd) begin
                            tgt_flash_q <= flash;
                            wr_q        <= is_wr;
                            bk_addr     <= tgt_addr;
                            bk_be_n     <= be_n;
                            bk_wdata    <= wdata;
                            st          <= ST_BUSY;
                        end else begin
                            rdata_q <= is_wr ? '0 : local_rdata;
                            st      <= ST_RESP;
                        end
                    end
                end
                ST_BUSY: begin
                    if (hit) begin
                        rdata_q <= wr_q ? '0 : (tgt_flash_q ? fl_rdata : reg_rdata);
                        st      <= ST_RESP;
                    end
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Back-side strobes follow the busy state and the captured target.
    always_comb begin
        fl_rd  = busy &&  tgt_flash_q && !wr_q;
        fl_wr  = busy &&  tgt_flash_q &&  wr_q;
        reg_rd = busy && !tgt_flash_q && !wr_q;
        reg_wr = busy && !tgt_flash_q &&  wr_q;
    end

    // Host response: data only shown while ready.
    always_comb begin
        h_ready = (st == ST_RESP);
        h_rdata = h_ready ? rdata_q : '0;
    end

endmodule

// File: rtl/iwin_port.sv
// Indirect access window top: pointer register at one offset, data
// register at another; data accesses are decoded against the pointer and
// either sent to a back-side target or answered locally. Keeps a sticky
// error flag for rejected accesses.
// Assumes one host strobe at a time, held until h_ready.
module iwin_port
    import iwin_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          DW         = 32,
    parameter int          OFS_W      = 3,
    parameter int          DATA_OFS   = 4,
    parameter int unsigned REG_LIMIT  = 32'h0002_0000,
    parameter int unsigned FLASH_BASE = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  h_ofs,
    input  logic [DW/8-1:0]   h_be_n,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [DW-1:0]     h_wdata,
    output logic [DW-1:0]     h_rdata,
    output logic              h_ready,
    output logic              err_o,
    output logic [ADDR_W-1:0] bk_addr,
    output logic [DW/8-1:0]   bk_be_n,
    output logic [DW-1:0]     bk_wdata,
    output logic              reg_rd,
    output logic              reg_wr,
    input  logic [DW-1:0]     reg_rdata,
    input  logic              reg_ready,
    output logic              fl_rd,
    output logic              fl_wr,
    input  logic [DW-1:0]     fl_rdata,
    input  logic              fl_ready
);

    localparam int               LANES     = DW / 8;
    localparam logic [OFS_W-1:0] PTR_OFS   = '0;
    localparam logic [OFS_W-1:0] DOFS      = OFS_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] LANE_MSK = ADDR_W'(LANES - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic              req;
    logic              is_ptr;
    logic              is_data;
    logic              accept;
    logic              full_be;
    logic              ptr_bad_wr;
    route_t            route;
    logic [DW-1:0]     local_rdata;
    logic [ADDR_W-1:0] tgt_addr;

    assign req      = h_rd || h_wr;
    assign is_ptr   = (h_ofs == PTR_OFS);
    assign is_data  = (h_ofs == DOFS);
    assign full_be  = (h_be_n == '0);
    assign tgt_addr = ptr_q & ~LANE_MSK;

    // Pointer write with partial lanes is rejected.
    assign ptr_bad_wr = is_ptr && h_wr && !full_be;

    // Locally answered read data: pointer readback, zero elsewhere.
    assign local_rdata = is_ptr ? DW'(ptr_q) : '0;

    iwin_decode #(
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .REG_LIMIT (REG_LIMIT),
        .FLASH_BASE(FLASH_BASE)
    ) u_dec (
        .ptr  (ptr_q),
        .be_n (h_be_n),
        .route(route)
    );

    iwin_seq #(
        .ADDR_W(ADDR_W),
        .DW    (DW),
        .LANES (LANES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .fwd        (is_data && route.fwd),
        .flash      (route.flash),
        .is_wr      (h_wr),
        .local_rdata(local_rdata),
        .tgt_addr   (tgt_addr),
        .be_n       (h_be_n),
        .wdata      (h_wdata),
        .accept     (accept),
        .h_ready    (h_ready),
        .h_rdata    (h_rdata),
        .bk_addr    (bk_addr),
        .bk_be_n    (bk_be_n),
        .bk_wdata   (bk_wdata),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_rdata  (reg_rdata),
        .reg_ready  (reg_ready),
        .fl_rd      (fl_rd),
        .fl_wr      (fl_wr),
        .fl_rdata   (fl_rdata),
        .fl_ready   (fl_ready)
    );

    // Pointer register: updated only by full-dword writes to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (accept && is_ptr && h_wr && full_be)
            ptr_q <= h_wdata[ADDR_W-1:0];
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (accept && ((is_data && route.err) || ptr_bad_wr))
            err_o <= 1'b1;
    end

endmodule

// File: rtl/iwin_port_chk.sv
// Property checker for iwin_port, attached with the bind below.
// Assumes the host and target handshake rules given in the brief.
module iwin_port_chk #(
    parameter int          ADDR_W     = 20,
    parameter int          DW         = 32,
    parameter int unsigned REG_LIMIT  = 32'h0002_0000,
    parameter int unsigned FLASH_BASE = 32'h0008_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_ready,
    input logic [DW-1:0]     h_rdata,
    input logic              err_o,
    input logic [ADDR_W-1:0] bk_addr,
    input logic [DW/8-1:0]   bk_be_n,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              reg_ready,
    input logic              fl_rd,
    input logic              fl_wr,
    input logic              fl_ready
);

    logic fl_stb;
    logic rg_stb;
    logic any_stb;
    logic hit;

    assign fl_stb  = fl_rd || fl_wr;
    assign rg_stb  = reg_rd || reg_wr;
    assign any_stb = fl_stb || rg_stb;
    assign hit     = (fl_stb && fl_ready) || (rg_stb && reg_ready);

    assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr, fl_rd, fl_wr}));

    assert_hold_until_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && !hit) |=> ($stable({reg_rd, reg_wr, fl_rd, fl_wr}) && $stable(bk_addr)
                               && $stable(bk_be_n) && !h_ready));

    assert_flash_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_stb |-> (32'(bk_addr) >= FLASH_BASE && bk_addr[1:0] == 2'b00));

    assert_regs_dword_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rg_stb |-> (bk_be_n == '0 && 32'(bk_addr) < REG_LIMIT));

    assert_no_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> (32'(bk_addr) < REG_LIMIT || 32'(bk_addr) >= FLASH_BASE));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);

    assert_rdata_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !h_ready |-> (h_rdata == '0));

    assert_ready_after_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> h_ready);

endmodule

bind iwin_port iwin_port_chk #(
    .ADDR_W    (ADDR_W),
    .DW        (DW),
    .REG_LIMIT (REG_LIMIT),
    .FLASH_BASE(FLASH_BASE)
) u_chk (.*);

// File: tb/tb_iwin_port.sv
`timescale 1ns/1ps
module tb_iwin_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  h_ofs = '0;
    logic [3:0]  h_be_n = '1;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic        err_o;
    logic [19:0] bk_addr;
    logic [3:0]  bk_be_n;
    logic [31:0] bk_wdata;
    logic        reg_rd, reg_wr, fl_rd, fl_wr;
    logic [31:0] reg_rdata, fl_rdata;
    logic        reg_ready, fl_ready;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    iwin_port dut (
        .clk(clk), .rst_n(rst_n), .h_ofs(h_ofs), .h_be_n(h_be_n),
        .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_ready(h_ready), .err_o(err_o), .bk_addr(bk_addr),
        .bk_be_n(bk_be_n), .bk_wdata(bk_wdata), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_rdata(fl_rdata), .fl_ready(fl_ready)
    );

    // Target models: ready after wait_n cycles of strobe, data from address.
    int         wait_n = 0;
    logic [7:0] fcnt = '0;
    logic [7:0] rcnt = '0;
    assign fl_rdata  = {12'hA5C, bk_addr};
    assign reg_rdata = {12'h3E7, bk_addr};
    assign fl_ready  = (fl_rd || fl_wr) && (fcnt == 8'(wait_n));
    assign reg_ready = (reg_rd || reg_wr) && (rcnt == 8'(wait_n));

    int          n_fwd = 0;
    logic [19:0] m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wd;
    logic        m_wr;
    logic        m_flash;

    always @(posedge clk) begin
        fcnt <= (fl_rd || fl_wr) ? fcnt + 8'd1 : 8'd0;
        rcnt <= (reg_rd || reg_wr) ? rcnt + 8'd1 : 8'd0;
        if ((fl_rd || fl_wr) && fl_ready || (reg_rd || reg_wr) && reg_ready) begin
            n_fwd   <= n_fwd + 1;
            m_addr  <= bk_addr;
            m_be    <= bk_be_n;
            m_wd    <= bk_wdata;
            m_wr    <= fl_wr || reg_wr;
            m_flash <= fl_rd || fl_wr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; h_rd = 1'b0; h_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input logic [2:0] ofs, input logic [3:0] be,
                          input bit wr, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        h_ofs = ofs; h_be_n = be; h_wdata = wd; h_rd = !wr; h_wr = wr;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!h_ready && cyc < 50);
        rd = h_rdata;
        h_rd = 1'b0; h_wr = 1'b0;
    endtask

    task automatic set_ptr(input logic [19:0] a);
        logic [31:0] rd;
        int cyc;
        access(3'd0, 4'b0000, 1'b1, {12'hFED, a}, rd, cyc);
    endtask

    // One data-register access at pointer a with enables be, checked in full.
    task automatic data_point(input logic [19:0] a, input logic [3:0] be, input bit wr);
        int zc, lo, hi, cyc, nf0;
        bit legal, dword, flash, regs, fwd, eerr;
        logic [31:0] rd, wd, exp_rd;
        zc = 0; lo = -1; hi = -1;
        for (int i = 0; i < 4; i++)
            if (!be[i]) begin zc++; if (lo < 0) lo = i; hi = i; end
        legal = (zc == 1 || zc == 2 || zc == 4) && (lo == int'(a[1:0]))
                && (int'(a[1:0]) % (zc == 0 ? 1 : zc) == 0) && (hi - lo + 1 == zc);
        dword = legal && zc == 4;
        flash = a >= 20'h80000;
        regs  = a < 20'h20000;
        fwd   = flash ? legal : (regs && dword);
        eerr  = flash ? !legal : !dword;
        wd    = {8'h5E, be, a};
        exp_rd = (fwd && !wr) ? {(flash ? 12'hA5C : 12'h3E7), a[19:2], 2'b00} : 32'h0;
        wait_n = int'(a[1:0] + be) % 3;
        nf0 = n_fwd;
        access(3'd4, be, wr, wd, rd, cyc);
        if (flash)     check(rd == exp_rd, fwd ? "R4 R8 rdata" : "R5 rdata", rd, exp_rd);
        else if (regs) check(rd == exp_rd, "R6 R8 rdata", rd, exp_rd);
        else           check(rd == exp_rd, "R7 rdata", rd, exp_rd);
        check(cyc == (fwd ? 2 + wait_n : 1), "R9 latency", cyc, fwd ? 2 + wait_n : 1);
        check((n_fwd - nf0) == (fwd ? 1 : 0), "R4 R6 R7 forward count", n_fwd - nf0, fwd);
        if (fwd) begin
            check(m_addr == {a[19:2], 2'b00} && m_be == be && m_flash == flash
                  && m_wr == wr && (!wr || m_wd == wd),
                  flash ? "R4 back fields" : "R6 back fields",
                  {m_addr, m_be, 3'b0, m_flash, 3'b0, m_wr}, {a[19:2], 2'b00, be, 3'b0, flash, 3'b0, wr});
        end
        check(err_o == eerr, flash ? "R5 err" : (regs ? "R6 err" : "R7 err"), err_o, eerr);
        if (eerr) begin
            do_reset();
            set_ptr(a);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        logic [19:0] bases [8];
        bases = '{20'h00000, 20'h1FFFC, 20'h20000, 20'h5A5A4,
                  20'h7FFFC, 20'h80000, 20'hC3F0C, 20'hFFFFC};

        do_reset();
        @(negedge clk);
        // R1: reset state
        check(!err_o && !h_ready && !(reg_rd || reg_wr || fl_rd || fl_wr) && h_rdata == 0,
              "R1 outputs", {err_o, h_ready, reg_rd, reg_wr, fl_rd, fl_wr}, 0);
        access(3'd0, 4'b0000, 1'b0, 0, rd, cyc);
        check(rd == 0, "R1 pointer", rd, 0);

        // R2: pointer write and readback, one-cycle completion
        access(3'd0, 4'b0000, 1'b1, 32'hABC9_8765, rd, cyc);
        check(cyc == 1, "R2 write latency", cyc, 1);
        access(3'd0, 4'b0000, 1'b0, 0, rd, cyc);
        check(rd == 32'h0009_8765, "R2 readback", rd, 32'h0009_8765);
        check(cyc == 1, "R2 read latency", cyc, 1);
        @(negedge clk);
        check(!h_ready && h_rdata == 0, "R12 idle", {h_ready, h_rdata[30:0]}, 0);

        // R11: other offsets have no effect
        for (int o = 1; o < 8; o++) begin
            if (o == 4) continue;
            access(3'(o), 4'b0000, 1'b1, 32'h0001_1111, rd, cyc);
            access(3'(o), 4'b0000, 1'b0, 0, rd, cyc);
            check(rd == 0 && cyc == 1 && !err_o, "R11 offset", {rd[29:0], err_o, 1'b0}, 0);
        end
        access(3'd0, 4'b0000, 1'b0, 0, rd, cyc);
        check(rd == 32'h0009_8765, "R11 pointer kept", rd, 32'h0009_8765);

        // R3: partial pointer writes ignored and flagged
        for (int b = 1; b < 16; b++) begin
            access(3'd0, 4'(b), 1'b1, 32'h0004_4444, rd, cyc);
            check(err_o, "R3 err", err_o, 1);
            access(3'd0, 4'b0000, 1'b0, 0, rd, cyc);
            check(rd == 32'h0009_8765, "R3 pointer kept", rd, 32'h0009_8765);
            do_reset();
            set_ptr(20'h98765);
        end

        // R10: error persists across legal accesses until reset
        set_ptr(20'h80001);
        access(3'd4, 4'b0000, 1'b0, 0, rd, cyc);
        set_ptr(20'h80000);
        for (int k = 0; k < 3; k++) begin
            access(3'd4, 4'b0000, 1'b0, 0, rd, cyc);
            check(err_o, "R10 sticky", err_o, 1);
        end
        do_reset();
        @(negedge clk);
        check(!err_o, "R10 cleared", err_o, 0);

        // R4-R9: sweep every enable pattern at each low offset per region
        foreach (bases[bi]) begin
            for (int k = 0; k < 4; k++) begin
                logic [19:0] a;
                a = bases[bi] + 20'(k);
                set_ptr(a);
                access(3'd0, 4'b0000, 1'b0, 0, rd, cyc);
                check(rd == {12'h0, a}, "R2 sweep readback", rd, {12'h0, a});
                for (int b = 0; b < 16; b++) begin
                    data_point(a, 4'(b), 1'b0);
                    data_point(a, 4'(b), 1'b1);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule